// File: doc/BRIEF.md
# Set-Associative TLB Lookup

This block caches recent virtual-to-physical page mappings for a small memory system with 14-bit virtual addresses, 12-bit physical addresses and 64-byte pages. It holds 16 mappings arranged as 4 sets of 4 ways. Each translation request is presented on the lookup port and answered in the same cycle. The answer is either a hit with the full physical address, or a miss. On a miss, the surrounding logic does no page-table access of its own through this block.

After a page-table walk done elsewhere, the resulting page number is installed through the fill port. A fill first reuses a way that already holds the same tag. Failing that, it takes the lowest free way. When the set is full, it evicts the way named by that set's rotating pointer. A single flush input drops every mapping at once, for example on an address-space switch.

Top module: `tlb_lookup`

## Requirements
- R1: The virtual address splits into page number VA[13:6] and offset VA[5:0]. The set is chosen by VA[7:6], and the tag is VA[13:8]. The same tag in a different set does not hit.
- R2: A lookup hits when a valid way of the selected set holds the probe tag. The result is combinational in the same cycle and gives lk_pa = {stored page number, VA[5:0]}. For example, with page 0x0F mapped to 0x0D, VA 0x03D4 returns 0x354.
- R3: On a miss, lk_hit is 0 and lk_pa is 0. A way whose tag matches but whose valid bit is clear counts as a miss.
- R4: After reset, every entry is invalid and every lookup misses.
- R5: A fill becomes visible from the clock edge that accepts it. A lookup in the same cycle still sees the old contents, and a lookup in the next cycle hits with the filled page number.
- R6: A fill whose tag is not present goes to the lowest-numbered invalid way of its set.
- R7: When all four ways of the set are valid, a fill replaces the way named by that set's pointer. The pointer is 0 after reset and advances by one, modulo 4, on each such replacement. Each set has its own pointer.
- R8: A fill whose tag is already valid in the set overwrites that way's page number. It creates no second copy and leaves the pointer unchanged.
- R9: flush_all invalidates every entry and returns every pointer to 0 at the next edge. A lookup in the flush cycle still sees the old contents.
- R10: When flush_all and fill_en are both high, the flush wins and the fill is dropped.
- R11: A fill changes only the set selected by its page number. Mappings in other sets are untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 14 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_pa | output | 12 | Physical address on a hit, zero on a miss |
| fill_en | input | 1 | Install a mapping at the next edge |
| fill_vpn | input | 8 | Virtual page number of the mapping |
| fill_ppn | input | 6 | Physical page number of the mapping |
| flush_all | input | 1 | Invalidate all entries at the next edge |

## Verification
Each kind of corrupted internal state shows up on the lookup port, and the bench probes it there.

- A wrong valid bit or stored tag appears as a spurious hit or miss. It shows on the first lookup of that page number after the faulty edge.
- A wrong stored page number appears in the upper bits of lk_pa on the same kind of lookup.
- A stray replacement pointer stays hidden until a set is full. It then shows as the wrong surviving mapping after the next fill to that set. For this reason, the bench fills sets past capacity several times and probes every resident page number after each fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // where the way picked for a fill comes from
  typedef enum logic [1:0] {
    VIC_MATCH = 2'd0,
    VIC_FREE  = 2'd1,
    VIC_ROT   = 2'd2
  } vic_src_e;
endpackage

// File: rtl/tlb_set_store.sv
module tlb_set_store #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         wr_en_i,
  input  logic [WAY_W-1:0]             wr_way_i,
  input  logic [TAG_W-1:0]             wr_tag_i,
  input  logic [PPN_W-1:0]             wr_ppn_i,
  input  logic                         adv_i,
  output logic [WAYS-1:0]              valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]   tag_o,
  output logic [WAYS-1:0][PPN_W-1:0]   ppn_o,
  output logic [WAY_W-1:0]             ptr_o
);
  logic [WAYS-1:0]            valid_q, valid_d;
  logic [WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [WAYS-1:0][PPN_W-1:0] ppn_q, ppn_d;
  logic [WAY_W-1:0]           ptr_q, ptr_d;
  logic                       upd_en;

  assign upd_en = clr_i | wr_en_i;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    ppn_d   = ppn_q;
    ptr_d   = ptr_q;
    if (clr_i) begin
      valid_d = '0;
      ptr_d   = '0;
    end else if (wr_en_i) begin
      valid_d[wr_way_i] = 1'b1;
      tag_d[wr_way_i]   = wr_tag_i;
      ppn_d[wr_way_i]   = wr_ppn_i;
      if (adv_i) begin
        if (ptr_q == WAY_W'(WAYS - 1)) ptr_d = '0;
        else                           ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      ppn_q   <= '0;
      ptr_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      ppn_q   <= ppn_d;
      ptr_q   <= ptr_d;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign ppn_o   = ppn_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/tlb_set_cmp.sv
module tlb_set_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           probe_i,
  output logic [WAYS-1:0]            hit_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = valid_i[w] && (tag_i[w] == probe_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  match_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             adv_o,
  output vic_src_e         src_o
);
  logic [WAY_W-1:0] match_way;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    match_way = '0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_i[w])  match_way = WAY_W'(w);
      if (!valid_i[w]) free_way  = WAY_W'(w);
    end
  end

  always_comb begin
    if (|match_i) begin
      src_o = VIC_MATCH;
      way_o = match_way;
    end else if (!(&valid_i)) begin
      src_o = VIC_FREE;
      way_o = free_way;
    end else begin
      src_o = VIC_ROT;
      way_o = ptr_i;
    end
    adv_o = (src_o == VIC_ROT);
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [VA_W-1:0]         lk_va,
  output logic                    lk_hit,
  output logic [PA_W-1:0]         lk_pa,
  input  logic                    fill_en,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [PA_W-OFF_W-1:0]   fill_ppn,
  input  logic                    flush_all
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0]            set_valid;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] set_tag;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] set_ppn;
  logic [SETS-1:0][WAY_W-1:0]           set_ptr;

  // lookup path
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  way_hit;
  logic [PPN_W-1:0] hit_ppn;

  assign lk_idx = lk_va[OFF_W +: IDX_W];
  assign lk_tag = lk_va[OFF_W + IDX_W +: TAG_W];

  tlb_set_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
    .valid_i (set_valid[lk_idx]),
    .tag_i   (set_tag[lk_idx]),
    .probe_i (lk_tag),
    .hit_o   (way_hit)
  );

  always_comb begin
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_ppn = hit_ppn | ({PPN_W{way_hit[w]}} & set_ppn[lk_idx][w]);
    end
  end

  assign lk_hit = |way_hit;
  assign lk_pa  = lk_hit ? {hit_ppn, lk_va[OFF_W-1:0]} : '0;

  // fill path
  logic [IDX_W-1:0] fl_idx;
  logic [TAG_W-1:0] fl_tag;
  logic [WAYS-1:0]  fl_match;
  logic [WAY_W-1:0] vic_way;
  logic             vic_adv;
  tlb_pkg::vic_src_e vic_src;

  assign fl_idx = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

  tlb_set_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_cmp (
    .valid_i (set_valid[fl_idx]),
    .tag_i   (set_tag[fl_idx]),
    .probe_i (fl_tag),
    .hit_o   (fl_match)
  );

  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i (set_valid[fl_idx]),
    .match_i (fl_match),
    .ptr_i   (set_ptr[fl_idx]),
    .way_o   (vic_way),
    .adv_o   (vic_adv),
    .src_o   (vic_src)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_wr;
    assign set_wr = fill_en && (fl_idx == IDX_W'(s));
    tlb_set_store #(
      .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .WAY_W(WAY_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (flush_all),
      .wr_en_i  (set_wr),
      .wr_way_i (vic_way),
      .wr_tag_i (fl_tag),
      .wr_ppn_i (fill_ppn),
      .adv_i    (vic_adv),
      .valid_o  (set_valid[s]),
      .tag_o    (set_tag[s]),
      .ppn_o    (set_ppn[s]),
      .ptr_o    (set_ptr[s])
    );
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int WAYS  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [VA_W-1:0]       lk_va,
  input logic                  lk_hit,
  input logic [PA_W-1:0]       lk_pa,
  input logic                  fill_en,
  input logic [VA_W-OFF_W-1:0] fill_vpn,
  input logic [PA_W-OFF_W-1:0] fill_ppn,
  input logic                  flush_all,
  input logic [WAYS-1:0]       way_hit
);
  // R3
  miss_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_all) |-> !lk_hit);

  // R8
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_en) && !$past(flush_all) &&
     (lk_va[VA_W-1:OFF_W] == $past(fill_vpn)))
    |-> (lk_hit && (lk_pa[PA_W-1:OFF_W] == $past(fill_ppn))));
endmodule

bind tlb_lookup tlb_lookup_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .WAYS(WAYS)
) u_tlb_lookup_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_va     (lk_va),
  .lk_hit    (lk_hit),
  .lk_pa     (lk_pa),
  .fill_en   (fill_en),
  .fill_vpn  (fill_vpn),
  .fill_ppn  (fill_ppn),
  .flush_all (flush_all),
  .way_hit   (way_hit)
);

// File: tb/test_tlb_lookup.sv
module test_tlb_lookup;
  logic        clk;
  logic        rst_n;
  logic [13:0] lk_va;
  logic        lk_hit;
  logic [11:0] lk_pa;
  logic        fill_en;
  logic [7:0]  fill_vpn;
  logic [5:0]  fill_ppn;
  logic        flush_all;

  int checks;
  int errors;

  tlb_lookup i_tlb_lookup (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .flush_all(flush_all)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference: 4 sets x 4 ways
  bit       m_v [4][4];
  bit [5:0] m_t [4][4];
  bit [5:0] m_p [4][4];
  int       m_ptr [4];

  always @(posedge clk or negedge rst_n) begin : model_upd
    int s;
    int w;
    bit found;
    if (!rst_n || flush_all) begin
      for (int i = 0; i < 4; i++) begin
        m_ptr[i] = 0;
        for (int j = 0; j < 4; j++) m_v[i][j] = 0;
      end
    end else if (fill_en) begin
      s = int'(fill_vpn[1:0]);
      found = 0;
      w = 0;
      for (int j = 0; j < 4; j++)
        if (!found && m_v[s][j] && m_t[s][j] == fill_vpn[7:2]) begin found = 1; w = j; end
      for (int j = 0; j < 4; j++)
        if (!found && !m_v[s][j]) begin found = 1; w = j; end
      if (!found) begin
        w = m_ptr[s];
        m_ptr[s] = (m_ptr[s] + 1) % 4;
      end
      m_v[s][w] = 1;
      m_t[s][w] = fill_vpn[7:2];
      m_p[s][w] = fill_ppn;
    end
  end

  function automatic void model_look(input logic [13:0] va, output logic h, output logic [11:0] pa);
    int s;
    s = int'(va[7:6]);
    h = 0;
    pa = '0;
    for (int j = 0; j < 4; j++)
      if (m_v[s][j] && m_t[s][j] == va[13:8]) begin h = 1; pa = {m_p[s][j], va[5:0]}; end
  endfunction

  task automatic compare(input string rq);
    logic eh;
    logic [11:0] epa;
    model_look(lk_va, eh, epa);
    checks++;
    if (lk_hit !== eh || lk_pa !== epa) begin
      errors++;
      $display("FAIL %s va=%h actual hit=%0b pa=%h expected hit=%0b pa=%h",
               rq, lk_va, lk_hit, lk_pa, eh, epa);
    end
  endtask

  task automatic expect_out(input string rq, input logic eh, input logic [11:0] epa);
    checks++;
    if (lk_hit !== eh || lk_pa !== epa) begin
      errors++;
      $display("FAIL %s va=%h actual hit=%0b pa=%h expected hit=%0b pa=%h",
               rq, lk_va, lk_hit, lk_pa, eh, epa);
    end
  endtask

  task automatic cyc(input logic [13:0] va, input logic fe, input logic [7:0] fv,
                     input logic [5:0] fp, input logic fl, input string rq);
    @(negedge clk);
    lk_va = va; fill_en = fe; fill_vpn = fv; fill_ppn = fp; flush_all = fl;
    #1;
    compare(rq);
  endtask

  task automatic look(input logic [7:0] vpn, input logic [5:0] off, input string rq);
    cyc({vpn, off}, 1'b0, 8'h00, 6'h00, 1'b0, rq);
  endtask

  task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn, input string rq);
    cyc(14'h0, 1'b1, vpn, ppn, 1'b0, rq);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 0; lk_va = '0; fill_en = 0; fill_vpn = '0; fill_ppn = '0; flush_all = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R4 reset state
    look(8'h0F, 6'h14, "R4");
    #1 expect_out("R4", 1'b0, 12'h000);
    look(8'h00, 6'h00, "R4");

    // R5 fill not visible in the same cycle
    cyc(14'h03D4, 1'b1, 8'h0F, 6'h0D, 1'b0, "R5");
    #1 expect_out("R5", 1'b0, 12'h000);
    // R2 example translation
    look(8'h0F, 6'h14, "R2");
    #1 expect_out("R2", 1'b1, 12'h354);

    // R1 same tag, different set misses
    fill(8'h3C, 6'h22, "R1");
    look(8'h3C, 6'h2A, "R1");
    #1 expect_out("R1", 1'b1, {6'h22, 6'h2A});
    look(8'h3D, 6'h2A, "R1");
    #1 expect_out("R1", 1'b0, 12'h000);

    // R6 fill set 2 ways in order
    fill({6'h01, 2'b10}, 6'h11, "R6");
    fill({6'h02, 2'b10}, 6'h12, "R6");
    fill({6'h03, 2'b10}, 6'h13, "R6");
    fill({6'h04, 2'b10}, 6'h14, "R6");
    for (int t = 1; t <= 4; t++) look({6'(t), 2'b10}, 6'h05, "R6");

    // R7 rotation through a full set
    fill({6'h05, 2'b10}, 6'h15, "R7");
    look({6'h01, 2'b10}, 6'h00, "R7");
    #1 expect_out("R7", 1'b0, 12'h000);
    fill({6'h06, 2'b10}, 6'h16, "R7");
    for (int t = 1; t <= 6; t++) look({6'(t), 2'b10}, 6'h01, "R7");

    // R8 overwrite existing tag, pointer unchanged
    fill({6'h03, 2'b10}, 6'h33, "R8");
    look({6'h03, 2'b10}, 6'h02, "R8");
    #1 expect_out("R8", 1'b1, {6'h33, 6'h02});
    fill({6'h07, 2'b10}, 6'h17, "R8");
    for (int t = 1; t <= 7; t++) look({6'(t), 2'b10}, 6'h03, "R8");

    // R3 matching tag with valid clear is a miss (covered after flush)
    // R11 other sets untouched
    look(8'h0F, 6'h14, "R11");
    #1 expect_out("R11", 1'b1, 12'h354);

    // R9 flush: same-cycle lookup sees old contents, then all miss
    cyc(14'h03D4, 1'b0, 8'h00, 6'h00, 1'b1, "R9");
    #1 expect_out("R9", 1'b1, 12'h354);
    look(8'h0F, 6'h14, "R3");
    #1 expect_out("R3", 1'b0, 12'h000);
    look({6'h07, 2'b10}, 6'h00, "R9");
    // R9 pointer back to 0
    for (int t = 8; t <= 12; t++) fill({6'(t), 2'b10}, 6'(t), "R9");
    for (int t = 8; t <= 12; t++) look({6'(t), 2'b10}, 6'h3F, "R9");

    // R10 flush beats fill
    cyc(14'h0, 1'b1, 8'h21, 6'h2B, 1'b1, "R10");
    look(8'h21, 6'h00, "R10");
    #1 expect_out("R10", 1'b0, 12'h000);

    // mixed traffic against the reference every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] v;
      int r;
      v = 8'($urandom_range(0, 31));
      r = $urandom_range(0, 99);
      cyc({8'($urandom_range(0, 31)), 6'($urandom)}, r < 30, v, 6'($urandom), r >= 98, "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule